// File: doc/BRIEF.md
# UART Receive Character-Timeout Detector

This block watches the receive side of a UART that runs with its FIFO enabled. It raises a pending flag for the interrupt identification logic when characters sit in the receive FIFO while nothing happens. Nothing happens means that no new character has arrived and the CPU has not read the FIFO for four whole character times. The flag lets software collect a partial burst that never reaches the FIFO trigger level.

Time is counted in ticks of the receiver's 16x oversampling enable. The timeout therefore follows the baud rate. One character time is the frame length in bits times 16 ticks. The frame length is built from the programmed data length, the parity enable and the stop-bit count, and it always includes the start bit. With two stop bits, the second one counts.

The timer restarts on any receive or read activity while no timeout is pending. Once the flag is up, only a CPU read clears it, and that read also restarts the timer. The timer and the flag are held cleared whenever the FIFO is empty or FIFO mode is off.

Top module: `uart_rx_idle_timeout`

## Requirements
- R1: Out of reset, `timeout_pend` is low.
- R2: The frame length in bits is 7 + `data_len` + `parity_en` + `two_stop`. That is one start bit, 5 to 8 data bits for `data_len` codes 0 to 3, an optional parity bit, and one or two stop bits.
- R3: With the FIFO non-empty and FIFO mode on, `timeout_pend` goes high on the clock edge that registers the (64 × frame length)-th `baud_tick` counted since the last restart. Up to that edge it stays low.
- R4: Setting `two_stop` lengthens the timeout by exactly 64 ticks.
- R5: A `push_stb` while no timeout is pending restarts the count from zero.
- R6: A `pop_stb` while no timeout is pending restarts the count from zero.
- R7: A `pop_stb` while a timeout is pending clears `timeout_pend` on the next edge and restarts the count.
- R8: A `push_stb` while a timeout is pending leaves `timeout_pend` high.
- R9: A zero `fifo_level` or a low `fifo_mode_en` clears `timeout_pend` and the count on the next edge. A later timeout needs a full new window.
- R10: Only `baud_tick` advances time, and no tick means no timeout. With a 12-bit frame, the window is 768 ticks. At 300 baud (4800 ticks per second) this is 160 ms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_mode_en | input | 1 | Receive FIFO mode enabled |
| fifo_level | input | LEVEL_W | Number of characters held in the receive FIFO |
| push_stb | input | 1 | One-cycle strobe: a character was written into the FIFO |
| pop_stb | input | 1 | One-cycle strobe: the CPU read a character from the FIFO |
| data_len | input | 2 | Data bits code: 0..3 selects 5..8 bits |
| parity_en | input | 1 | Parity bit present in the frame |
| two_stop | input | 1 | Two stop bits instead of one |
| baud_tick | input | 1 | 16x oversampling enable from the baud generator |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
A count that restarts wrongly or that slips shows up as `timeout_pend` rising one or more ticks too early or too late. The bench sees this on the cycle after the boundary tick, because it probes the last tick before the window closes and the first tick after it, for every frame configuration. A flag that fails to clear or to hold is visible one clock after the read, push, empty or disable event that should have changed it. A timer that was not cleared shows up within one window, because the flag then rises before a full fresh window has passed.

// File: rtl/uart_rxto_pkg.sv
package uart_rxto_pkg;
   localparam int unsigned FRAME_W        = 4;
   localparam int unsigned MIN_FRAME_BITS = 7;
   localparam int unsigned MAX_FRAME_BITS = 12;
   typedef logic [FRAME_W-1:0] frame_len_t;
   typedef enum logic [1:0] {DATA5 = 2'd0, DATA6 = 2'd1, DATA7 = 2'd2, DATA8 = 2'd3} data_len_e;
endpackage

// File: rtl/uart_rxto_frame.sv
module uart_rxto_frame
   import uart_rxto_pkg::*;
#(
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned CHAR_TIMES = 4,
   parameter int unsigned CNT_W      = 10
) (
   input  logic [1:0]       data_len,
   input  logic             parity_en,
   input  logic             two_stop,
   output frame_len_t       frame_bits,
   output logic [CNT_W-1:0] limit
);
   localparam int unsigned WIN_PER_BIT = OVERSAMPLE * CHAR_TIMES;
   localparam bit          IS_POW2     = (WIN_PER_BIT & (WIN_PER_BIT - 1)) == 0;

   initial begin
      assert (CNT_W >= $clog2(WIN_PER_BIT * MAX_FRAME_BITS + 1))
         else $error("CNT_W too narrow for longest window");
      assert (WIN_PER_BIT > 0) else $error("window must be non-zero");
   end

   // start + 5..8 data + parity + 1..2 stop (R2)
   always_comb begin
      frame_bits = frame_len_t'(MIN_FRAME_BITS) + frame_len_t'(data_len)
                 + frame_len_t'(parity_en) + frame_len_t'(two_stop);
   end

   generate
      if (IS_POW2) begin : g_shift
         localparam int unsigned SH = $clog2(WIN_PER_BIT);
         assign limit = CNT_W'(frame_bits) << SH;
      end else begin : g_mult
         assign limit = CNT_W'(frame_bits) * CNT_W'(WIN_PER_BIT);
      end
   endgenerate

   always_comb begin
      p_frame_range_r2 : assert (frame_bits >= frame_len_t'(MIN_FRAME_BITS)
                                 && frame_bits <= frame_len_t'(MAX_FRAME_BITS));
   end
endmodule

// File: rtl/uart_rxto_timer.sv
module uart_rxto_timer #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             push,
   input  logic             pop,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             pend
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   cnt_nxt;

   assign cnt_nxt = {1'b0, cnt} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else if (!active) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else if (pend) begin
         if (pop) begin
            pend <= 1'b0;
            cnt  <= '0;
         end
      end else if (push || pop) begin
         cnt <= '0;
      end else if (tick) begin
         if (cnt_nxt >= {1'b0, limit}) begin
            pend <= 1'b1;
            cnt  <= '0;
         end else begin
            cnt <= cnt_nxt[CNT_W-1:0];
         end
      end
   end

   p_idle_clear_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (!pend && cnt == '0));
   p_pop_clears_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (active && pend && pop) |=> !pend);
   p_push_keeps_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (active && pend && !pop) |=> pend);
   p_tick_needed_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!pend && !tick) |=> !pend);
   p_restart_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (active && !pend && (push || pop)) |=> (cnt == '0 && !pend));
endmodule

// File: rtl/uart_rx_idle_timeout.sv
module uart_rx_idle_timeout
   import uart_rxto_pkg::*;
#(
   parameter int unsigned LEVEL_W    = 5,
   parameter int unsigned OVERSAMPLE = 16,
   parameter int unsigned CHAR_TIMES = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fifo_mode_en,
   input  logic [LEVEL_W-1:0] fifo_level,
   input  logic               push_stb,
   input  logic               pop_stb,
   input  logic [1:0]         data_len,
   input  logic               parity_en,
   input  logic               two_stop,
   input  logic               baud_tick,
   output logic               timeout_pend
);
   localparam int unsigned CNT_W = $clog2(OVERSAMPLE * CHAR_TIMES * MAX_FRAME_BITS + 1);

   initial begin
      assert (LEVEL_W > 0) else $error("LEVEL_W must be positive");
      assert (OVERSAMPLE > 0 && CHAR_TIMES > 0) else $error("bad timing parameters");
   end

   frame_len_t       frame_bits;
   logic [CNT_W-1:0] limit;
   logic             active;

   assign active = fifo_mode_en && (fifo_level != '0);

   uart_rxto_frame #(
      .OVERSAMPLE(OVERSAMPLE), .CHAR_TIMES(CHAR_TIMES), .CNT_W(CNT_W)
   ) u_frame (
      .data_len(data_len), .parity_en(parity_en), .two_stop(two_stop),
      .frame_bits(frame_bits), .limit(limit)
   );

   uart_rxto_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .active(active), .push(push_stb), .pop(pop_stb),
      .tick(baud_tick), .limit(limit), .pend(timeout_pend)
   );

   p_empty_low_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_level == '0) |=> !timeout_pend);
endmodule

// File: tb/sim_uart_rx_idle_timeout.sv
module sim_uart_rx_idle_timeout;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fifo_mode_en = 1'b0;
   logic [4:0] fifo_level = '0;
   logic       push_stb = 1'b0, pop_stb = 1'b0;
   logic [1:0] data_len = '0;
   logic       parity_en = 1'b0, two_stop = 1'b0, baud_tick = 1'b0;
   logic       timeout_pend;
   int         n_run = 0, n_fail = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   uart_rx_idle_timeout u0 (
      .clk(clk), .rst_n(rst_n), .fifo_mode_en(fifo_mode_en), .fifo_level(fifo_level),
      .push_stb(push_stb), .pop_stb(pop_stb), .data_len(data_len),
      .parity_en(parity_en), .two_stop(two_stop), .baud_tick(baud_tick),
      .timeout_pend(timeout_pend)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) baud_tick = 1'b1;
         @(negedge clk) baud_tick = 1'b0;
      end
   endtask

   task automatic push1();
      @(negedge clk) push_stb = 1'b1;
      @(negedge clk) push_stb = 1'b0;
   endtask

   task automatic pop1();
      @(negedge clk) pop_stb = 1'b1;
      @(negedge clk) pop_stb = 1'b0;
   endtask

   task automatic cfg(input int dl, input int par, input int st);
      @(negedge clk);
      data_len = 2'(dl); parity_en = par[0]; two_stop = st[0];
   endtask

   function automatic int win(input int dl, input int par, input int st);
      return 64 * (7 + dl + par + st);
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_fail++; n_run++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int L;
      int n;
      repeat (3) @(negedge clk);
      chk("R1 reset", timeout_pend, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after release", timeout_pend, 0);
      fifo_mode_en = 1'b1; fifo_level = 5'd1;

      // R2/R3 sweep over every frame configuration
      for (int dl = 0; dl < 4; dl++)
         for (int par = 0; par < 2; par++)
            for (int st = 0; st < 2; st++) begin
               cfg(dl, par, st);
               L = win(dl, par, st);
               pop1();
               ticks(L - 1);
               chk($sformatf("R3 R2 early dl=%0d p=%0d s=%0d", dl, par, st), timeout_pend, 0);
               ticks(1);
               chk($sformatf("R3 R2 edge dl=%0d p=%0d s=%0d", dl, par, st), timeout_pend, 1);
               pop1();
               chk("R7 sweep clear", timeout_pend, 0);
            end

      // R4: second stop bit adds 64 ticks
      cfg(0, 0, 1); pop1();
      ticks(448);
      chk("R4 one-stop window not enough", timeout_pend, 0);
      ticks(63);
      chk("R4 before extended edge", timeout_pend, 0);
      ticks(1);
      chk("R4 extended edge", timeout_pend, 1);

      // R5: push restarts
      cfg(0, 0, 0); pop1();
      ticks(300); push1();
      ticks(447);
      chk("R5 restarted by push", timeout_pend, 0);
      ticks(1);
      chk("R5 full window after push", timeout_pend, 1);

      // R8: push while pending keeps flag
      push1();
      chk("R8 push keeps pending", timeout_pend, 1);

      // R7: pop clears and restarts
      pop1();
      chk("R7 pop clears", timeout_pend, 0);
      ticks(447);
      chk("R7 restart window", timeout_pend, 0);
      ticks(1);
      chk("R7 new timeout", timeout_pend, 1);

      // R6: pop before timeout restarts
      pop1(); ticks(400); pop1();
      ticks(447);
      chk("R6 restarted by pop", timeout_pend, 0);
      ticks(1);
      chk("R6 full window after pop", timeout_pend, 1);

      // R9: empty clears flag and timer
      @(negedge clk) fifo_level = 5'd0;
      @(negedge clk);
      chk("R9 empty clears", timeout_pend, 0);
      ticks(500);
      chk("R9 empty blocks timeout", timeout_pend, 0);
      fifo_level = 5'd3;
      ticks(447);
      chk("R9 timer cleared by empty", timeout_pend, 0);
      ticks(1);
      chk("R9 timeout after refill", timeout_pend, 1);
      @(negedge clk) fifo_mode_en = 1'b0;
      @(negedge clk);
      chk("R9 disable clears", timeout_pend, 0);
      fifo_mode_en = 1'b1;
      ticks(200);
      @(negedge clk) fifo_mode_en = 1'b0;
      @(negedge clk) fifo_mode_en = 1'b1;
      ticks(447);
      chk("R9 timer cleared by disable", timeout_pend, 0);
      ticks(1);
      chk("R9 timeout after enable", timeout_pend, 1);

      // R10: no ticks, no timeout; 12-bit frame proportion
      pop1();
      repeat (3000) @(negedge clk);
      chk("R10 no tick no timeout", timeout_pend, 0);
      cfg(3, 1, 1); pop1();
      n = 0;
      while (!timeout_pend && n < 2000) begin
         ticks(1);
         n++;
      end
      chk("R10 12-bit window ticks", n, 768);
      chk("R10 delay ms at 300 baud", (n * 1000) / (16 * 300), 160);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule